// File: doc/BRIEF.md
# OTP fuse read controller

This block sits between a simple register bus and a one-time-programmable fuse array. It fetches one 32-bit fuse word per request. Software first places a fuse word address in the control register and loads pulse widths into the timing register. It then writes the start bit of the read-trigger register. A sequencer runs the array through three phases: enable lead-in, read strobe, and enable tail. Once the tail ends, it captures the word into the read-data register and drops the busy flag.

The control register has direct, bit-set and bit-clear addresses, so single fields can change without a read-modify-write. Failures are reported in two ways. The error flag in control goes high and stays high until software clears it. The read-data register holds the poison word 0xBADABADA in place of fuse contents. Failures include an array fault at capture, an address beyond the implemented fuse range, and a start issued while a read is already running. Fuse burning, shadow reload and clock generation are not part of the block. The program-width field and the write-data register are only stored.

Top module: `otp_read_ctrl`

## Requirements
- R1: After reset, the control, timing, write-data and read-data registers read 0, and fuse_en and fuse_rstrobe are low.
- R2: A write to the control register at offset 0x00 loads the fuse address from bits 6:0, the reload flag from bit 10 and the key field from bits 31:16. Bits 8 (busy) and 9 (error) ignore this write, and every other bit reads 0.
- R3: A write to 0x04 ORs the written value into control. A write to 0x08 clears each control bit written as 1, which includes the error bit 9. Busy (bit 8) is unaffected by both. Offsets 0x04 and 0x08 read back the control register.
- R4: The timing register at 0x10 holds the strobe-read width in bits 21:16, the relax time in bits 15:12 and the program width in bits 11:0. All other bits read 0.
- R5: Writing a value with bit 0 set to the read-trigger register at 0x30 starts a read of the address in control bits 6:0. Writing bit 0 as 0 has no effect. fuse_addr presents that address for the whole read.
- R6: Busy (control bit 8) reads 1 from the cycle after an accepted start, for 2*(relax+1)+(strobe_read+1) cycles. fuse_en is high for exactly those cycles.
- R7: fuse_rstrobe goes high after relax+1 cycles of enable and stays high for strobe_read+1 cycles, always while fuse_en is high.
- R8: When busy falls, the read-data register at 0x40 holds the fuse word sampled at the end of the tail phase.
- R9: If fuse_fault is high when the word is captured, read data becomes 0xBADABADA and the error bit is set.
- R10: A start at an address at or above FUSE_WORDS runs no array cycle and never raises busy. It sets the error bit and loads 0xBADABADA into read data on the next cycle.
- R11: A start issued while busy is ignored and sets the error bit. The running read completes with its original address and length.
- R12: Any start that is not ignored clears the key field (control bits 31:16).
- R13: Once set, the error bit stays set, even through later successful reads, until a 1 is written to bit 9 at 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, valid with bus_sel |
| bus_addr | input | BUS_AW | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| fuse_addr | output | ADDR_W | Word address presented to the fuse array |
| fuse_en | output | 1 | Array enable |
| fuse_rstrobe | output | 1 | Array read strobe |
| fuse_rdata | input | 32 | Word returned by the array |
| fuse_fault | input | 1 | Array fault indication, sampled at capture |

## Verification
An accepted start is registered on the clock edge that ends the trigger write. Busy and fuse_en rise immediately after that edge and stay high for 2*(relax+1)+(strobe_read+1) cycles. The strobe starts relax+1 cycles into that window. Read data and error change on the same edge where busy falls. A rejected out-of-range start shows its poison word and error one edge after the trigger. The bench drives every input half a period away from the rising edge and samples outputs one time unit later. Each read is followed cycle by cycle, counting busy, enable and strobe cycles and the strobe's first cycle, and these are compared with the formulas for each timing setting.

// File: rtl/otp_pkg.sv
package otp_pkg;
   localparam int REG_W        = 32;
   // register byte offsets
   localparam int OFS_CTRL     = 'h00;
   localparam int OFS_CTRL_SET = 'h04;
   localparam int OFS_CTRL_CLR = 'h08;
   localparam int OFS_TIMING   = 'h10;
   localparam int OFS_WDATA    = 'h20;
   localparam int OFS_TRIGGER  = 'h30;
   localparam int OFS_RDATA    = 'h40;
   // control fields
   localparam int CTL_BUSY_BIT = 8;
   localparam int CTL_ERR_BIT  = 9;
   localparam int CTL_RLD_BIT  = 10;
   localparam int CTL_KEY_LSB  = 16;
   localparam int CTL_KEY_W    = 16;
   // timing fields
   localparam int TIM_SR_LSB   = 16;
   localparam int TIM_SR_MAX   = 6;
   localparam int TIM_RLX_LSB  = 12;
   localparam int TIM_RLX_MAX  = 4;
   localparam int TIM_PRG_LSB  = 0;
   localparam int TIM_PRG_MAX  = 12;
   localparam logic [REG_W-1:0] POISON_WORD = 32'hBADA_BADA;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_LEAD,
      SQ_STROBE,
      SQ_TAIL
   } seq_state_t;
endpackage

// File: rtl/otp_seq.sv
module otp_seq
   import otp_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int SR_W   = 6,
   parameter int RLX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [RLX_W-1:0]  relax,
   input  logic [SR_W-1:0]   strobe_w,
   output logic              busy,
   output logic              done,
   output logic [ADDR_W-1:0] fuse_addr,
   output logic              fuse_en,
   output logic              fuse_rstrobe
);
   localparam int CNT_W = (SR_W > RLX_W) ? SR_W : RLX_W;

   seq_state_t        state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] addr_q;
   logic [RLX_W-1:0]  rlx_q;
   logic [SR_W-1:0]   sr_q;
   logic              rlx_end;
   logic              sr_end;

   assign rlx_end = (cnt_q == CNT_W'(rlx_q));
   assign sr_end  = (cnt_q == CNT_W'(sr_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         cnt_q   <= '0;
         addr_q  <= '0;
         rlx_q   <= '0;
         sr_q    <= '0;
      end else begin
         unique case (state_q)
            SQ_IDLE: begin
               if (start) begin
                  state_q <= SQ_LEAD;
                  cnt_q   <= '0;
                  addr_q  <= start_addr;
                  rlx_q   <= relax;
                  sr_q    <= strobe_w;
               end
            end
            SQ_LEAD: begin
               if (rlx_end) begin
                  state_q <= SQ_STROBE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            SQ_STROBE: begin
               if (sr_end) begin
                  state_q <= SQ_TAIL;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            SQ_TAIL: begin
               if (rlx_end) begin
                  state_q <= SQ_IDLE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign busy         = (state_q != SQ_IDLE);
   assign done         = (state_q == SQ_TAIL) && rlx_end;
   assign fuse_addr    = addr_q;
   assign fuse_en      = busy;
   assign fuse_rstrobe = (state_q == SQ_STROBE);
endmodule

// File: rtl/otp_regs.sv
module otp_regs
   import otp_pkg::*;
#(
   parameter int ADDR_W     = 7,
   parameter int FUSE_WORDS = 96,
   parameter int SR_W       = 6,
   parameter int RLX_W      = 4,
   parameter int PRG_W      = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_ctrl,
   input  logic                 wr_set,
   input  logic                 wr_clr,
   input  logic                 wr_tim,
   input  logic                 wr_wdat,
   input  logic                 go_req,
   input  logic [REG_W-1:0]     wdata,
   input  logic                 busy,
   input  logic                 done,
   input  logic [REG_W-1:0]     cap_data,
   input  logic                 cap_fault,
   output logic [ADDR_W-1:0]    ctrl_addr,
   output logic [CTL_KEY_W-1:0] ctrl_key,
   output logic                 ctrl_reload,
   output logic                 err_flag,
   output logic [SR_W-1:0]      tim_sread,
   output logic [RLX_W-1:0]     tim_relax,
   output logic [PRG_W-1:0]     tim_prog,
   output logic [REG_W-1:0]     wdat_q,
   output logic [REG_W-1:0]     rdat_q,
   output logic                 seq_start
);
   logic                 in_range;
   logic                 start_taken;
   logic                 err_evt;
   logic [ADDR_W-1:0]    adr_n;
   logic [CTL_KEY_W-1:0] key_n;
   logic                 rld_n;
   logic                 err_n;

   generate
      if (FUSE_WORDS == (1 << ADDR_W)) begin : g_full_range
         assign in_range = 1'b1;
      end else begin : g_part_range
         assign in_range = (32'(ctrl_addr) < 32'(FUSE_WORDS));
      end
   endgenerate

   assign start_taken = go_req && !busy;
   assign seq_start   = start_taken && in_range;
   assign err_evt     = (go_req && busy) || (start_taken && !in_range) || (done && cap_fault);

   always_comb begin
      adr_n = ctrl_addr;
      key_n = ctrl_key;
      rld_n = ctrl_reload;
      err_n = err_flag;
      if (wr_ctrl) begin
         adr_n = wdata[ADDR_W-1:0];
         key_n = wdata[CTL_KEY_LSB +: CTL_KEY_W];
         rld_n = wdata[CTL_RLD_BIT];
      end else if (wr_set) begin
         adr_n = ctrl_addr   | wdata[ADDR_W-1:0];
         key_n = ctrl_key    | wdata[CTL_KEY_LSB +: CTL_KEY_W];
         rld_n = ctrl_reload | wdata[CTL_RLD_BIT];
         err_n = err_flag    | wdata[CTL_ERR_BIT];
      end else if (wr_clr) begin
         adr_n = ctrl_addr   & ~wdata[ADDR_W-1:0];
         key_n = ctrl_key    & ~wdata[CTL_KEY_LSB +: CTL_KEY_W];
         rld_n = ctrl_reload & ~wdata[CTL_RLD_BIT];
         err_n = err_flag    & ~wdata[CTL_ERR_BIT];
      end
      if (start_taken) key_n = '0;
      if (err_evt)     err_n = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_addr   <= '0;
         ctrl_key    <= '0;
         ctrl_reload <= 1'b0;
         err_flag    <= 1'b0;
      end else begin
         ctrl_addr   <= adr_n;
         ctrl_key    <= key_n;
         ctrl_reload <= rld_n;
         err_flag    <= err_n;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tim_sread <= '0;
         tim_relax <= '0;
         tim_prog  <= '0;
         wdat_q    <= '0;
      end else begin
         if (wr_tim) begin
            tim_sread <= wdata[TIM_SR_LSB  +: SR_W];
            tim_relax <= wdata[TIM_RLX_LSB +: RLX_W];
            tim_prog  <= wdata[TIM_PRG_LSB +: PRG_W];
         end
         if (wr_wdat) wdat_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdat_q <= '0;
      end else if (done) begin
         rdat_q <= cap_fault ? POISON_WORD : cap_data;
      end else if (start_taken && !in_range) begin
         rdat_q <= POISON_WORD;
      end
   end
endmodule

// File: rtl/otp_read_ctrl.sv
module otp_read_ctrl
   import otp_pkg::*;
#(
   parameter int ADDR_W     = 7,
   parameter int FUSE_WORDS = 96,
   parameter int SR_W       = 6,
   parameter int RLX_W      = 4,
   parameter int PRG_W      = 12,
   parameter int BUS_AW     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [ADDR_W-1:0] fuse_addr,
   output logic              fuse_en,
   output logic              fuse_rstrobe,
   input  logic [31:0]       fuse_rdata,
   input  logic              fuse_fault
);
   generate
      if (ADDR_W < 1 || ADDR_W > CTL_BUSY_BIT) begin : g_bad_addr_w
         $error("ADDR_W must lie in 1..8");
      end
      if (FUSE_WORDS < 1 || FUSE_WORDS > (1 << ADDR_W)) begin : g_bad_words
         $error("FUSE_WORDS must lie in 1..2**ADDR_W");
      end
      if (SR_W < 1 || SR_W > TIM_SR_MAX || RLX_W < 1 || RLX_W > TIM_RLX_MAX
          || PRG_W < 1 || PRG_W > TIM_PRG_MAX) begin : g_bad_tim
         $error("timing field widths exceed their register slots");
      end
      if (BUS_AW < 7) begin : g_bad_bus
         $error("BUS_AW too narrow for the register map");
      end
   endgenerate

   logic                 wr_any;
   logic                 wr_ctrl, wr_set, wr_clr, wr_tim, wr_wdat, go_req;
   logic                 busy, done, seq_start;
   logic [ADDR_W-1:0]    ctrl_addr;
   logic [CTL_KEY_W-1:0] ctrl_key;
   logic                 ctrl_reload, err_flag;
   logic [SR_W-1:0]      tim_sread;
   logic [RLX_W-1:0]     tim_relax;
   logic [PRG_W-1:0]     tim_prog;
   logic [REG_W-1:0]     wdat_q, rdat_q;
   logic [REG_W-1:0]     ctrl_rd, tim_rd;

   assign wr_any  = bus_sel && bus_wr;
   assign wr_ctrl = wr_any && (bus_addr == BUS_AW'(OFS_CTRL));
   assign wr_set  = wr_any && (bus_addr == BUS_AW'(OFS_CTRL_SET));
   assign wr_clr  = wr_any && (bus_addr == BUS_AW'(OFS_CTRL_CLR));
   assign wr_tim  = wr_any && (bus_addr == BUS_AW'(OFS_TIMING));
   assign wr_wdat = wr_any && (bus_addr == BUS_AW'(OFS_WDATA));
   assign go_req  = wr_any && (bus_addr == BUS_AW'(OFS_TRIGGER)) && bus_wdata[0];

   otp_regs #(
      .ADDR_W(ADDR_W), .FUSE_WORDS(FUSE_WORDS),
      .SR_W(SR_W), .RLX_W(RLX_W), .PRG_W(PRG_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_ctrl(wr_ctrl), .wr_set(wr_set), .wr_clr(wr_clr),
      .wr_tim(wr_tim), .wr_wdat(wr_wdat), .go_req(go_req),
      .wdata(bus_wdata), .busy(busy), .done(done),
      .cap_data(fuse_rdata), .cap_fault(fuse_fault),
      .ctrl_addr(ctrl_addr), .ctrl_key(ctrl_key),
      .ctrl_reload(ctrl_reload), .err_flag(err_flag),
      .tim_sread(tim_sread), .tim_relax(tim_relax), .tim_prog(tim_prog),
      .wdat_q(wdat_q), .rdat_q(rdat_q), .seq_start(seq_start)
   );

   otp_seq #(
      .ADDR_W(ADDR_W), .SR_W(SR_W), .RLX_W(RLX_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .start(seq_start), .start_addr(ctrl_addr),
      .relax(tim_relax), .strobe_w(tim_sread),
      .busy(busy), .done(done),
      .fuse_addr(fuse_addr), .fuse_en(fuse_en), .fuse_rstrobe(fuse_rstrobe)
   );

   always_comb begin
      ctrl_rd = '0;
      ctrl_rd[ADDR_W-1:0]                 = ctrl_addr;
      ctrl_rd[CTL_BUSY_BIT]               = busy;
      ctrl_rd[CTL_ERR_BIT]                = err_flag;
      ctrl_rd[CTL_RLD_BIT]                = ctrl_reload;
      ctrl_rd[CTL_KEY_LSB +: CTL_KEY_W]   = ctrl_key;
      tim_rd = '0;
      tim_rd[TIM_SR_LSB  +: SR_W]  = tim_sread;
      tim_rd[TIM_RLX_LSB +: RLX_W] = tim_relax;
      tim_rd[TIM_PRG_LSB +: PRG_W] = tim_prog;
   end

   always_comb begin
      if (bus_addr == BUS_AW'(OFS_CTRL) || bus_addr == BUS_AW'(OFS_CTRL_SET)
          || bus_addr == BUS_AW'(OFS_CTRL_CLR))   bus_rdata = ctrl_rd;
      else if (bus_addr == BUS_AW'(OFS_TIMING))    bus_rdata = tim_rd;
      else if (bus_addr == BUS_AW'(OFS_WDATA))     bus_rdata = wdat_q;
      else if (bus_addr == BUS_AW'(OFS_RDATA))     bus_rdata = rdat_q;
      else                                         bus_rdata = '0;
   end
endmodule

// File: rtl/otp_read_ctrl_chk.sv
module otp_read_ctrl_chk
   import otp_pkg::*;
#(
   parameter int ADDR_W     = 7,
   parameter int FUSE_WORDS = 96,
   parameter int BUS_AW     = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bus_sel,
   input logic                 bus_wr,
   input logic [BUS_AW-1:0]    bus_addr,
   input logic                 wd_go,
   input logic                 wd_err,
   input logic                 busy,
   input logic                 err_flag,
   input logic [ADDR_W-1:0]    ctrl_addr,
   input logic [CTL_KEY_W-1:0] ctrl_key,
   input logic [ADDR_W-1:0]    fuse_addr,
   input logic                 fuse_en,
   input logic                 fuse_rstrobe
);
   logic go, clr_err, far;

   assign go      = bus_sel && bus_wr && (bus_addr == BUS_AW'(OFS_TRIGGER)) && wd_go;
   assign clr_err = bus_sel && bus_wr && (bus_addr == BUS_AW'(OFS_CTRL_CLR)) && wd_err;
   assign far     = (32'(ctrl_addr) >= 32'(FUSE_WORDS));

   AST_STROBE_INSIDE_EN: assert property (@(posedge clk) disable iff (!rst_n)
      fuse_rstrobe |-> fuse_en); // R7
   AST_EN_TRACKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      fuse_en == busy); // R6
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> $stable(fuse_addr)); // R5
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag && !clr_err |=> err_flag); // R13
   AST_BUSY_START_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      go && busy |=> err_flag); // R11
   AST_RANGE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      go && !busy && far |=> !busy && err_flag); // R10
   AST_KEY_WIPED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ctrl_key == '0); // R12
endmodule

bind otp_read_ctrl otp_read_ctrl_chk #(
   .ADDR_W(ADDR_W), .FUSE_WORDS(FUSE_WORDS), .BUS_AW(BUS_AW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .wd_go(bus_wdata[0]), .wd_err(bus_wdata[9]),
   .busy(busy), .err_flag(err_flag), .ctrl_addr(ctrl_addr),
   .ctrl_key(ctrl_key), .fuse_addr(fuse_addr), .fuse_en(fuse_en),
   .fuse_rstrobe(fuse_rstrobe)
);

// File: tb/sim_otp_read_ctrl.sv
module sim_otp_read_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [6:0]  fuse_addr;
   logic        fuse_en, fuse_rstrobe;
   logic [31:0] fuse_rdata;
   logic        fuse_fault;
   logic        fault_on = 1'b0;
   logic [6:0]  fault_addr = '0;

   int checks = 0;
   int fails  = 0;
   bit done_flag = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [31:0] fw(input logic [6:0] a);
      return {16'hC0DE, 1'b0, a, 1'b1, ~a};
   endfunction

   assign fuse_rdata = fw(fuse_addr);
   assign fuse_fault = fault_on && (fuse_addr == fault_addr);

   otp_read_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .fuse_addr(fuse_addr), .fuse_en(fuse_en), .fuse_rstrobe(fuse_rstrobe),
      .fuse_rdata(fuse_rdata), .fuse_fault(fuse_fault)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   // called at a negedge; one write cycle, returns at the next negedge
   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   // follow a running read until busy drops
   task automatic measure(input logic [6:0] a, output int bc, output int ec,
                          output int sc, output int first, output bit addr_ok);
      logic [31:0] d;
      bc = 0; ec = 0; sc = 0; first = -1; addr_ok = 1;
      for (int i = 0; i < 400; i++) begin
         bus_read(8'h00, d);
         if (!d[8]) break;
         bc++;
         if (fuse_en) ec++;
         if (fuse_rstrobe) begin
            if (first < 0) first = i;
            sc++;
         end
         if (fuse_addr != a) addr_ok = 0;
         @(negedge clk);
      end
   endtask

   task automatic run_read(input logic [6:0] a, input int rl, input int sr, input string tag);
      logic [31:0] d;
      int bc, ec, sc, first, n;
      bit aok;
      n = 2*(rl+1) + sr + 1;
      bus_write(8'h10, (32'(sr) << 16) | (32'(rl) << 12) | 32'h0AB);
      bus_write(8'h00, 32'h3E77_0000 | 32'(a));
      bus_write(8'h30, 32'h1);
      bus_read(8'h00, d);
      check(d[31:16] == 16'h0, {tag, " R12 key cleared"}, {16'h0, d[31:16]}, 32'h0);
      measure(a, bc, ec, sc, first, aok);
      check(bc == n, {tag, " R6 busy length"}, bc, n);
      check(ec == n, {tag, " R6 enable length"}, ec, n);
      check(sc == sr+1, {tag, " R7 strobe length"}, sc, sr+1);
      check(first == rl+1, {tag, " R7 strobe start"}, first, rl+1);
      check(aok, {tag, " R5 fuse_addr held"}, 32'(aok), 1);
      bus_read(8'h40, d);
      check(d == fw(a), {tag, " R8 read data"}, d, fw(a));
   endtask

   task automatic t_reset();
      logic [31:0] d;
      bus_read(8'h00, d); check(d == 0, "R1 ctrl reset", d, 0);
      bus_read(8'h10, d); check(d == 0, "R1 timing reset", d, 0);
      bus_read(8'h20, d); check(d == 0, "R1 wdata reset", d, 0);
      bus_read(8'h40, d); check(d == 0, "R1 rdata reset", d, 0);
      check(!fuse_en && !fuse_rstrobe, "R1 array idle", {fuse_en, fuse_rstrobe}, 0);
   endtask

   task automatic t_ctrl();
      logic [31:0] d;
      bus_write(8'h00, 32'hFFFF_FFFF);
      bus_read(8'h00, d); check(d == 32'hFFFF_047F, "R2 ctrl write mask", d, 32'hFFFF_047F);
      bus_write(8'h00, 32'h0);
      bus_read(8'h00, d); check(d == 0, "R2 ctrl cleared", d, 0);
      bus_write(8'h20, 32'h1234_5678);
      bus_read(8'h20, d); check(d == 32'h1234_5678, "R2 wdata storage", d, 32'h1234_5678);
   endtask

   task automatic t_alias();
      logic [31:0] d;
      bus_write(8'h00, 32'h05);
      bus_write(8'h04, 32'h400);
      bus_read(8'h04, d); check(d == 32'h405, "R3 set alias OR", d, 32'h405);
      bus_write(8'h08, 32'h4);
      bus_read(8'h08, d); check(d == 32'h401, "R3 clear alias", d, 32'h401);
      bus_write(8'h04, 32'h300);
      bus_read(8'h00, d); check(d == 32'h601, "R3 set error, busy ignored", d, 32'h601);
      bus_write(8'h00, 32'h0);
      bus_read(8'h00, d); check(d == 32'h200, "R2 direct write keeps error", d, 32'h200);
      bus_write(8'h08, 32'h200);
      bus_read(8'h00, d); check(d == 32'h0, "R3 clear error bit 9", d, 0);
   endtask

   task automatic t_timing();
      logic [31:0] d;
      bus_write(8'h10, 32'hFFFF_FFFF);
      bus_read(8'h10, d); check(d == 32'h003F_FFFF, "R4 timing mask", d, 32'h003F_FFFF);
      bus_write(8'h10, 32'h0025_3123);
      bus_read(8'h10, d); check(d == 32'h0025_3123, "R4 timing fields", d, 32'h0025_3123);
   endtask

   task automatic t_reads();
      logic [31:0] d;
      run_read(7'h11, 2, 3, "rdA");
      run_read(7'h00, 0, 0, "rdB");
      run_read(7'h5F, 15, 63, "rdC");
      bus_write(8'h30, 32'h2);
      bus_read(8'h00, d); check(d[8] == 1'b0, "R5 trigger bit0 clear no start", d, 32'h5F);
      check(!fuse_en, "R5 no enable after bit0 clear", 32'(fuse_en), 0);
      bus_read(8'h00, d); check(d[9] == 1'b0, "R13 no error on good reads", d, 32'h5F);
   endtask

   task automatic t_fault();
      logic [31:0] d;
      int bc, ec, sc, first;
      bit aok;
      fault_on = 1'b1; fault_addr = 7'h22;
      bus_write(8'h10, 32'h0001_1000);
      bus_write(8'h00, 32'h22);
      bus_write(8'h30, 32'h1);
      measure(7'h22, bc, ec, sc, first, aok);
      bus_read(8'h40, d); check(d == 32'hBADA_BADA, "R9 fault poison", d, 32'hBADA_BADA);
      bus_read(8'h00, d); check(d[9], "R9 fault error", d, 32'h222);
      fault_on = 1'b0;
      run_read(7'h23, 1, 1, "stk");
      bus_read(8'h00, d); check(d[9], "R13 error sticky after good read", d, 32'h223);
      bus_write(8'h08, 32'h200);
      bus_read(8'h00, d); check(!d[9], "R13 cleared by alias", d, 32'h023);
   endtask

   task automatic t_range();
      logic [31:0] d;
      bus_write(8'h00, 32'h3E77_0070);
      bus_write(8'h30, 32'h1);
      bus_read(8'h00, d);
      check(d == 32'h0000_0270, "R10 out of range error, no busy; R12 key cleared", d, 32'h270);
      check(!fuse_en, "R10 no array enable", 32'(fuse_en), 0);
      bus_read(8'h40, d); check(d == 32'hBADA_BADA, "R10 poison word", d, 32'hBADA_BADA);
      @(negedge clk);
      check(!fuse_en && !fuse_rstrobe, "R10 array still idle", {fuse_en, fuse_rstrobe}, 0);
      bus_write(8'h08, 32'h200);
   endtask

   task automatic t_busy();
      logic [31:0] d;
      int bc, ec, sc, first;
      bit aok;
      bus_write(8'h10, 32'h0005_3000);
      bus_write(8'h00, 32'h10);
      bus_write(8'h30, 32'h1);
      bus_write(8'h00, 32'h20);
      bus_write(8'h30, 32'h1);
      bus_read(8'h00, d); check(d[9] && d[8], "R11 start while busy flags error", d, 32'h320);
      measure(7'h10, bc, ec, sc, first, aok);
      check(bc + 2 == 14, "R11 original length kept", bc + 2, 14);
      check(aok, "R11 original address kept", 32'(aok), 1);
      bus_read(8'h40, d); check(d == fw(7'h10), "R11 original data", d, fw(7'h10));
      bus_read(8'h00, d); check(d[8:0] == 9'h020 && d[9], "R11 no second read", d, 32'h220);
   endtask

   initial begin
      for (int c = 0; c < WATCHDOG; c++) begin
         @(posedge clk);
         if (done_flag) break;
      end
      if (!done_flag) begin
         checks++; fails++;
         $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ctrl();
      t_alias();
      t_timing();
      t_reads();
      t_fault();
      t_range();
      t_busy();
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule